// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block joins a flit producer to a flit consumer across one point-to-point link. It keeps flits from being lost by using credits. The sending side holds a count of the free slots in the receiving buffer. It forwards a flit only while that count is above zero, and spends one credit on each flit it sends. The receiving side places each arriving flit in a FIFO. When its consumer removes flits, it hands the freed slots back to the sender as credits.

Credits are not returned one at a time. Freed slots collect in a pending count. That count goes out as a single credit message when it reaches a batch threshold, or when a cycle passes with no dequeue. The forward link and the credit path each pass through a pipeline whose depth is a parameter. With the default sizes, the FIFO is deep enough to cover the full credit round trip plus the batching delay. A producer facing an always-ready consumer therefore never stalls.

Top module: `credit_link`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. The sender's credit count equals FIFO_DEPTH, so exactly FIFO_DEPTH flits are accepted while the consumer holds out_ready at 0.
- R2: Once FIFO_DEPTH flits are outstanding with none freed, in_ready is 0 and no further flit is accepted.
- R3: Each accepted flit uses one credit. Credits held by the sender, flits in flight, FIFO contents, pending freed slots and credits in flight always add up to FIFO_DEPTH, and the sender never holds more than FIFO_DEPTH.
- R4: Credits are returned only for slots freed by a consumer dequeue. With out_ready held at 0, in_ready stays 0 indefinitely.
- R5: Back-to-back dequeues are held until BATCH_THRESH slots are pending. They are then returned in one credit message whose count equals the number of slots freed, and the sender gains exactly that many credits.
- R6: If a cycle passes with no dequeue while freed slots are pending, all pending slots are returned in the next cycle.
- R7: Every accepted flit is delivered exactly once and in order, whatever the consumer's out_ready pattern.
- R8: With out_ready held at 1, the default configuration accepts a flit every cycle. in_ready never drops while in_valid is held high.
- R9: In a cycle where a flit is sent and a credit message arrives, the credit count changes by the returned count minus one.
- R10: A flit is never written into a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a flit |
| in_ready | output | 1 | Sender holds at least one credit |
| in_data | input | FLIT_W | Flit from producer |
| out_valid | output | 1 | FIFO holds a flit |
| out_ready | input | 1 | Consumer takes the flit |
| out_data | output | FLIT_W | Flit at the FIFO head |

## Verification
The hardest cases to reach are the credit-return paths when the sender is starved. The bench first holds the consumer idle until all credits are spent. It then grants the consumer small budgets of dequeues: one, then three, then two. Each budget makes the receiver return either an idle flush or a full batch. The number of extra flits the producer can then push shows the returned count at the ports. Table-driven runs with mixed consumer patterns then check delivery order and full link throughput.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
  // bits needed to hold a count from 0 up to n inclusive
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cl_pipe.sv
module cl_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_vld,
  input  logic [W-1:0] d,
  output logic         q_vld,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_wire
      assign q_vld = d_vld;
      assign q     = d;
    end else begin : g_regs
      logic [STAGES-1:0] vld_sr;
      logic [W-1:0]      dat_sr [STAGES];
      always_ff @(posedge clk) begin
        if (rst) vld_sr <= '0;
        else     vld_sr <= {vld_sr[STAGES-2 >= 0 ? STAGES-2 : 0:0], d_vld} & {STAGES{1'b1}};
      end
      always_ff @(posedge clk) begin
        dat_sr[0] <= d;
        for (int i = 1; i < STAGES; i++) dat_sr[i] <= dat_sr[i-1];
      end
      assign q_vld = vld_sr[STAGES-1];
      assign q     = dat_sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cl_sender.sv
module cl_sender #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  output logic              link_vld,
  output logic [FLIT_W-1:0] link_data,
  input  logic              crd_vld,
  input  logic [CNT_W-1:0]  crd_cnt,
  output logic [CNT_W-1:0]  credits
);
  logic [CNT_W-1:0] credit_q;
  logic [CNT_W:0]   credit_nx;
  logic             fire;

  assign in_ready = (credit_q != '0);
  assign fire     = in_valid && in_ready;
  assign credits  = credit_q;

  always_comb begin
    credit_nx = {1'b0, credit_q} - (CNT_W+1)'(fire);
    if (crd_vld) credit_nx = credit_nx + {1'b0, crd_cnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= CNT_W'(DEPTH);
      link_vld <= 1'b0;
    end else begin
      credit_q <= credit_nx[CNT_W-1:0];
      link_vld <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) link_data <= in_data;
  end
endmodule

// File: rtl/cl_receiver.sv
module cl_receiver #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 16,
  parameter int BATCH  = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_vld,
  input  logic [FLIT_W-1:0] link_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              crd_vld,
  output logic [CNT_W-1:0]  crd_cnt,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  pending
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  level_q, pend_q, tot;
  logic              pop, flush;

  assign out_valid = (level_q != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;
  assign level     = level_q;
  assign pending   = pend_q;

  always_ff @(posedge clk) begin
    if (link_vld) mem[wr_ptr] <= link_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (link_vld) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)      rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      level_q <= level_q + CNT_W'(link_vld) - CNT_W'(pop);
    end
  end

  // credit batching: collect freed slots, flush on threshold or idle consumer
  assign tot   = pend_q + CNT_W'(pop);
  assign flush = (tot >= CNT_W'(BATCH)) || ((pend_q != '0) && !pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      crd_vld <= 1'b0;
      crd_cnt <= '0;
    end else begin
      crd_vld <= flush;
      crd_cnt <= flush ? tot : '0;
      pend_q  <= flush ? '0 : tot;
    end
  end
endmodule

// File: rtl/credit_link.sv
module credit_link
  import credit_link_pkg::*;
#(
  parameter int FLIT_W       = 16,
  parameter int FIFO_DEPTH   = 16,
  parameter int BATCH_THRESH = 3,
  parameter int LINK_DLY     = 2,
  parameter int CRED_DLY     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data
);
  localparam int CNT_W = cnt_bits(FIFO_DEPTH);

  logic              tx_vld, rx_vld, snd_fire, rx_pop;
  logic [FLIT_W-1:0] tx_data, rx_data;
  logic              crd_tx_vld, crd_rx_vld;
  logic [CNT_W-1:0]  crd_tx_cnt, crd_rx_cnt;
  logic [CNT_W-1:0]  credits, level, pending;

  assign snd_fire = in_valid && in_ready;
  assign rx_pop   = out_valid && out_ready;

  cl_sender #(.FLIT_W(FLIT_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_snd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .link_vld(tx_vld), .link_data(tx_data),
    .crd_vld(crd_rx_vld), .crd_cnt(crd_rx_cnt), .credits(credits)
  );

  cl_pipe #(.W(FLIT_W), .STAGES(LINK_DLY)) u_fwd (
    .clk(clk), .rst(rst), .d_vld(tx_vld), .d(tx_data), .q_vld(rx_vld), .q(rx_data)
  );

  cl_pipe #(.W(CNT_W), .STAGES(CRED_DLY)) u_ret (
    .clk(clk), .rst(rst), .d_vld(crd_tx_vld), .d(crd_tx_cnt), .q_vld(crd_rx_vld), .q(crd_rx_cnt)
  );

  cl_receiver #(.FLIT_W(FLIT_W), .DEPTH(FIFO_DEPTH), .BATCH(BATCH_THRESH), .CNT_W(CNT_W)) u_rcv (
    .clk(clk), .rst(rst), .link_vld(rx_vld), .link_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .crd_vld(crd_tx_vld), .crd_cnt(crd_tx_cnt), .level(level), .pending(pending)
  );
endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk #(
  parameter int DEPTH = 16,
  parameter int BATCH = 3,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             send,
  input logic [CNT_W-1:0] credits,
  input logic             link_wr,
  input logic [CNT_W-1:0] level,
  input logic             pop,
  input logic [CNT_W-1:0] pending,
  input logic             crd_tx_vld,
  input logic [CNT_W-1:0] crd_tx_cnt,
  input logic             crd_rx_vld,
  input logic [CNT_W-1:0] crd_rx_cnt
);
  int flits_air, crd_air;

  always_ff @(posedge clk) begin
    if (rst) begin
      flits_air <= 0;
      crd_air   <= 0;
    end else begin
      flits_air <= flits_air + (send ? 1 : 0) - (link_wr ? 1 : 0);
      crd_air   <= crd_air + (crd_tx_vld ? int'(crd_tx_cnt) : 0) - (crd_rx_vld ? int'(crd_rx_cnt) : 0);
    end
  end

  AST_CREDIT_CONSERVED: assert property (@(posedge clk) disable iff (rst)
    int'(credits) + flits_air + int'(level) + int'(pending) + crd_air
      + (crd_tx_vld ? int'(crd_tx_cnt) : 0) == DEPTH); // R3
  AST_CREDIT_CEILING: assert property (@(posedge clk) disable iff (rst)
    int'(credits) <= DEPTH); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    link_wr |-> (int'(level) < DEPTH)); // R10
  AST_RETURN_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    crd_tx_vld |-> ($past(pop) || $past(pending != '0))); // R4
  AST_BATCH_SIZE: assert property (@(posedge clk) disable iff (rst)
    crd_tx_vld |-> (crd_tx_cnt != '0 && int'(crd_tx_cnt) <= BATCH)); // R5
  AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (pending != '0 && !pop) |=> (crd_tx_vld && crd_tx_cnt == $past(pending))); // R6
  AST_SEND_AND_RETURN: assert property (@(posedge clk) disable iff (rst)
    (send && crd_rx_vld) |=> (int'(credits) == int'($past(credits)) + int'($past(crd_rx_cnt)) - 1)); // R9
endmodule

bind credit_link credit_link_chk #(.DEPTH(FIFO_DEPTH), .BATCH(BATCH_THRESH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .send(snd_fire), .credits(credits), .link_wr(rx_vld), .level(level),
  .pop(rx_pop), .pending(pending), .crd_tx_vld(crd_tx_vld), .crd_tx_cnt(crd_tx_cnt),
  .crd_rx_vld(crd_rx_vld), .crd_rx_cnt(crd_rx_cnt)
);

// File: tb/credit_link_bench.sv
module credit_link_bench;
  localparam int FW = 16, DEPTH = 16;
  localparam int NV = 4;
  // entry: {flit count[7:0], consumer mode[2:0], throughput check[0]}
  localparam logic [11:0] VEC [NV] = '{
    {8'd40, 3'd0, 1'b1},
    {8'd30, 3'd1, 1'b0},
    {8'd25, 3'd2, 1'b0},
    {8'd12, 3'd0, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 0;
  logic [FW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [FW-1:0] out_data;

  int checks = 0, fails = 0;
  int sent = 0, rcvd = 0, target = 0, stalls = 0, ord_err = 0, budget = 0, cyc = 0;
  int cmode = 3;
  logic [FW-1:0] base = '0, bad_got = '0, bad_exp = '0;
  bit done = 0;

  always #5 clk = ~clk;

  credit_link u_credit_link (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // producer and consumer both act on the falling edge
  always @(negedge clk) if (!rst) begin
    case (cmode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      2: out_ready = (cyc % 3 == 0);
      3: out_ready = 1'b0;
      default: out_ready = (budget > 0);
    endcase
    if (out_ready && out_valid) begin
      if (out_data !== 16'(base + rcvd)) begin
        if (ord_err == 0) begin bad_got = out_data; bad_exp = 16'(base + rcvd); end
        ord_err++;
      end
      rcvd++;
      if (cmode == 4) budget--;
    end
    in_valid = (sent < target);
    in_data  = 16'(base + sent);
    if (in_valid && in_ready) sent++;
    else if (in_valid) stalls++;
    cyc++;
  end

  task automatic wait_rcvd(input int n, input string req);
    int t = 0;
    while (rcvd < n && t < 2000) begin @(posedge clk); t++; end
    check(req, rcvd, n);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #2;
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // table-driven runs
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); #1;
      base = 16'(v * 256); sent = 0; rcvd = 0; stalls = 0; ord_err = 0;
      cmode = int'(VEC[v][3:1]);
      target = int'(VEC[v][11:4]);
      wait_rcvd(target, "R7 delivered count");
      check("R7 order errors", ord_err, 0);
      if (ord_err != 0) $display("FAIL R7: first bad flit got %h expected %h", bad_got, bad_exp);
      if (VEC[v][0]) check("R8 R9 producer stalls", stalls, 0);
      repeat (20) @(posedge clk);
    end

    // directed: fill with idle consumer
    @(negedge clk); #1;
    base = 16'h8000; sent = 0; rcvd = 0; ord_err = 0; cmode = 3; target = 100;
    repeat (40) @(posedge clk);
    #2;
    check("R1 R2 flits accepted with idle consumer", sent, DEPTH);
    check("R2 in_ready at zero credits", int'(in_ready), 0);
    repeat (30) @(posedge clk);
    #2;
    check("R4 no credits without dequeue", sent, DEPTH);
    // one dequeue then idle: flushed single credit
    budget = 1; cmode = 4;
    repeat (20) @(posedge clk);
    #2;
    check("R6 idle flush returns one credit", sent, DEPTH + 1);
    check("R2 stalled again", int'(in_ready), 0);
    // three back-to-back dequeues: one batch of three
    budget = 3;
    repeat (20) @(posedge clk);
    #2;
    check("R5 batch of three credits", sent, DEPTH + 4);
    // two dequeues then idle
    budget = 2;
    repeat (20) @(posedge clk);
    #2;
    check("R5 R6 partial batch of two", sent, DEPTH + 6);
    check("R10 FIFO held at depth", int'(out_valid), 1);
    // drain
    target = DEPTH + 6; cmode = 0;
    wait_rcvd(DEPTH + 6, "R7 drain count");
    check("R7 drain order", ord_err, 0);
    repeat (10) @(posedge clk);
    #2;
    check("R3 all credits back", int'(in_ready), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule